// File: doc/BRIEF.md
# Atomic Memory Primitive Unit

This block sits in front of a small word-addressed memory that several requesters share. Each requester has its own request port carrying an operation code, a word address and write data. A round-robin arbiter picks at most one request per cycle. The chosen operation runs against the memory at the next clock edge. Because only one operation runs per cycle, every read-modify-write is indivisible with respect to the other requesters.

The supported operations are plain load, plain store, atomic swap, load-linked and store-conditional. Each requester owns one link entry, made of a valid flag and a linked word address. Load-linked fills the entry. A store-conditional writes memory only when the entry is valid and its address equals the request address, and it returns a 1 or 0 status in place of data. Every write to memory kills the matching link entries of all other requesters. Software can build locks on top of these operations: a word holding zero is free, and a nonzero word is held.

Top module: `atomic_mon`

## Requirements
- R1: After reset every memory word reads 0. A load (op code 0) returns the addressed word. A store (op code 1) writes its data to the addressed word and returns 0.
- R2: A swap (op code 2) returns the old word and writes the new data in the same cycle. Swapping 1 into a lock word returns 0 when the lock is free and nonzero when it is held, and storing 0 releases the lock.
- R3: A load-linked (op code 3) returns the addressed word and records its address, marked valid, in the requester's link entry.
- R4: A store-conditional (op code 4) whose requester holds a valid link to the same address writes the data and returns 1.
- R5: A store-conditional whose address differs from the requester's linked address leaves memory unchanged and returns 0.
- R6: A store, a swap or a successful store-conditional to an address clears the link of every other requester linked to that address. The writer's own link is kept.
- R7: Reset clears every link entry. A store-conditional made without a valid link fails and returns 0. Every store-conditional, whether it succeeds or fails, clears its requester's own link.
- R8: At most one grant is high per cycle, and only to a requester whose valid is high. The search starts at the requester that follows the last winner, and requester 0 comes first after reset.
- R9: The response (valid, requester index, data) is registered and appears in the cycle after the grant. There is no response in a cycle after a cycle with no grant.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | NREQ | Request present, one bit per requester |
| req_op | input | 3*NREQ | Op code per requester (0 load, 1 store, 2 swap, 3 load-linked, 4 store-conditional) |
| req_addr | input | AW*NREQ | Word address per requester |
| req_wdata | input | DW*NREQ | Write data per requester |
| gnt | output | NREQ | One-hot grant; the request is taken at the next edge |
| rsp_valid | output | 1 | Response present |
| rsp_id | output | $clog2(NREQ) | Requester index the response belongs to |
| rsp_data | output | DW | Read data, or the 0/1 status for a store-conditional |

## Verification
A sequence of single-requester operations walks load, store and swap over fresh and previously written words. It then runs load-linked and store-conditional pairs in four situations: untouched, consumed by an earlier conditional, broken by another requester's store or swap, and aimed at a different address. Each of these separates a correct link check from one that ignores the valid flag, the address or the clearing rules. A lock acquire, contend and release sequence confirms that swap returns the old word. With every requester asking at once, the grant order shows that the pointer rotates. Two sparse requesters then show that the search skips idle ports and starts after the last winner.

// File: rtl/atomic_mon_pkg.sv
package atomic_mon_pkg;
    typedef enum logic [2:0] {
        OP_LOAD  = 3'd0,
        OP_STORE = 3'd1,
        OP_SWAP  = 3'd2,
        OP_LL    = 3'd3,
        OP_SC    = 3'd4
    } op_e;
endpackage

// File: rtl/rr_arbiter.sv
module rr_arbiter #(
    parameter int N = 4,
    localparam int IW = $clog2(N)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [N-1:0]  req,
    output logic [N-1:0]  gnt,
    output logic [IW-1:0] gnt_id
);
    logic [IW-1:0] ptr_d, ptr_q;
    logic          found;
    int            idx;

    // Rotating search: first requester at or after the pointer wins.
    always_comb begin
        gnt    = '0;
        gnt_id = '0;
        found  = 1'b0;
        ptr_d  = ptr_q;
        idx    = 0;
        for (int off = 0; off < N; off++) begin
            idx = (int'(ptr_q) + off) % N;
            if (!found && req[idx]) begin
                found      = 1'b1;
                gnt[idx]   = 1'b1;
                gnt_id     = IW'(idx);
                ptr_d      = IW'((idx + 1) % N);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ptr_q <= '0;
        else        ptr_q <= ptr_d;
    end
endmodule

// File: rtl/word_mem.sv
module word_mem #(
    parameter int AW = 4,
    parameter int DW = 16,
    localparam int DEPTH = 1 << AW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata
);
    logic [DW-1:0] mem_q [DEPTH];
    logic [DW-1:0] mem_d [DEPTH];

    assign rdata = mem_q[addr];

    always_comb begin
        for (int i = 0; i < DEPTH; i++) mem_d[i] = mem_q[i];
        if (we) mem_d[addr] = wdata;
    end

    always_ff @(posedge clk) begin
        for (int i = 0; i < DEPTH; i++) begin
            if (!rst_n) mem_q[i] <= '0;
            else        mem_q[i] <= mem_d[i];
        end
    end
endmodule

// File: rtl/link_table.sv
module link_table #(
    parameter int N  = 4,
    parameter int AW = 4,
    localparam int IW = $clog2(N)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            ll_en,
    input  logic            sc_en,
    input  logic            wr_en,
    input  logic [IW-1:0]   op_id,
    input  logic [AW-1:0]   op_addr,
    output logic [N-1:0]    lnk_valid,
    output logic [N*AW-1:0] lnk_addr
);
    typedef struct packed {
        logic          valid;
        logic [AW-1:0] addr;
    } entry_t;

    for (genvar g = 0; g < N; g++) begin : g_entry
        entry_t ent_d, ent_q;
        logic   own;

        assign own = (op_id == IW'(g));

        always_comb begin
            ent_d = ent_q;
            // A write by someone else to the linked word breaks the link.
            if (wr_en && !own && ent_q.valid && ent_q.addr == op_addr)
                ent_d.valid = 1'b0;
            if (own && ll_en) begin
                ent_d.valid = 1'b1;
                ent_d.addr  = op_addr;
            end
            if (own && sc_en)
                ent_d.valid = 1'b0;
        end

        always_ff @(posedge clk) begin
            if (!rst_n) ent_q <= '0;
            else        ent_q <= ent_d;
        end

        assign lnk_valid[g]           = ent_q.valid;
        assign lnk_addr[g*AW +: AW]   = ent_q.addr;
    end
endmodule

// File: rtl/atomic_mon.sv
module atomic_mon
    import atomic_mon_pkg::*;
#(
    parameter int NREQ = 4,
    parameter int AW   = 4,
    parameter int DW   = 16,
    localparam int IW  = $clog2(NREQ)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NREQ-1:0]   req_valid,
    input  logic [3*NREQ-1:0] req_op,
    input  logic [AW*NREQ-1:0] req_addr,
    input  logic [DW*NREQ-1:0] req_wdata,
    output logic [NREQ-1:0]   gnt,
    output logic              rsp_valid,
    output logic [IW-1:0]     rsp_id,
    output logic [DW-1:0]     rsp_data
);
    typedef struct packed {
        logic          valid;
        logic [IW-1:0] id;
        logic [DW-1:0] data;
    } rsp_t;

    rsp_t            st_d, st_q;
    logic [IW-1:0]   sel_id;
    op_e             sel_op;
    logic [AW-1:0]   sel_addr;
    logic [DW-1:0]   sel_wdata;
    logic            granted;
    logic [NREQ-1:0] lnk_valid;
    logic [NREQ*AW-1:0] lnk_addr;
    logic [AW-1:0]   own_lnk_addr;
    logic            sc_ok;
    logic            mem_we;
    logic [DW-1:0]   mem_rdata;
    logic            sc_taken;

    rr_arbiter #(.N(NREQ)) u_arb (
        .clk    (clk),
        .rst_n  (rst_n),
        .req    (req_valid),
        .gnt    (gnt),
        .gnt_id (sel_id)
    );

    assign granted   = |gnt;
    assign sel_op    = op_e'(req_op[sel_id*3 +: 3]);
    assign sel_addr  = req_addr[sel_id*AW +: AW];
    assign sel_wdata = req_wdata[sel_id*DW +: DW];

    assign own_lnk_addr = lnk_addr[sel_id*AW +: AW];
    assign sc_ok        = lnk_valid[sel_id] && (own_lnk_addr == sel_addr);
    assign sc_taken     = granted && (sel_op == OP_SC);

    assign mem_we = granted && ((sel_op == OP_STORE) || (sel_op == OP_SWAP) ||
                                (sel_op == OP_SC && sc_ok));

    word_mem #(.AW(AW), .DW(DW)) u_mem (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (mem_we),
        .addr  (sel_addr),
        .wdata (sel_wdata),
        .rdata (mem_rdata)
    );

    link_table #(.N(NREQ), .AW(AW)) u_lnk (
        .clk       (clk),
        .rst_n     (rst_n),
        .ll_en     (granted && sel_op == OP_LL),
        .sc_en     (sc_taken),
        .wr_en     (mem_we),
        .op_id     (sel_id),
        .op_addr   (sel_addr),
        .lnk_valid (lnk_valid),
        .lnk_addr  (lnk_addr)
    );

    always_comb begin
        st_d       = st_q;
        st_d.valid = granted;
        if (granted) begin
            st_d.id = sel_id;
            unique case (sel_op)
                OP_LOAD, OP_SWAP, OP_LL: st_d.data = mem_rdata;
                OP_SC:                   st_d.data = DW'(sc_ok);
                default:                 st_d.data = '0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rsp_valid = st_q.valid;
    assign rsp_id    = st_q.id;
    assign rsp_data  = st_q.data;
endmodule

// File: rtl/atomic_mon_chk.sv
module atomic_mon_chk #(
    parameter int NREQ = 4,
    parameter int DW   = 16
) (
    input logic            clk,
    input logic            rst_n,
    input logic [NREQ-1:0] req_valid,
    input logic [NREQ-1:0] gnt,
    input logic            rsp_valid,
    input logic [DW-1:0]   rsp_data,
    input logic            sc_taken
);
    a_r8_one_grant: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(gnt));

    a_r8_grant_requested: assert property (@(posedge clk) disable iff (!rst_n)
        (gnt & ~req_valid) == '0);

    a_r9_rsp_after_grant: assert property (@(posedge clk) disable iff (!rst_n)
        (|gnt) |=> rsp_valid);

    a_r9_no_rsp_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !(|gnt) |=> !rsp_valid);

    // R4 and R5: the status of a store-conditional is 0 or 1.
    a_r4_sc_status: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && $past(sc_taken)) |-> (rsp_data <= DW'(1)));
endmodule

bind atomic_mon atomic_mon_chk #(.NREQ(NREQ), .DW(DW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .gnt       (gnt),
    .rsp_valid (rsp_valid),
    .rsp_data  (rsp_data),
    .sc_taken  (sc_taken)
);

// File: tb/atomic_mon_tb.sv
`timescale 1ns/1ps
module atomic_mon_tb;
    localparam int NREQ = 4;
    localparam int AW   = 4;
    localparam int DW   = 16;
    localparam int IW   = $clog2(NREQ);
    // Vector: {id[2], op[3], addr[4], wdata[16], expected data[16]}
    localparam int NV = 32;
    localparam logic [40:0] VEC [NV] = '{
        {2'd0, 3'd4, 4'd5, 16'h0009, 16'h0000}, // R7 SC with no link fails
        {2'd0, 3'd0, 4'd5, 16'h0000, 16'h0000}, // R1/R7 memory untouched
        {2'd0, 3'd1, 4'd5, 16'h0007, 16'h0000}, // R1 store returns 0
        {2'd1, 3'd0, 4'd5, 16'h0000, 16'h0007}, // R1 load sees store
        {2'd1, 3'd2, 4'd5, 16'h0011, 16'h0007}, // R2 swap returns old
        {2'd2, 3'd0, 4'd5, 16'h0000, 16'h0011}, // R2 new value written
        {2'd0, 3'd3, 4'd5, 16'h0000, 16'h0011}, // R3 LL returns word
        {2'd0, 3'd4, 4'd5, 16'h0022, 16'h0001}, // R4 SC succeeds
        {2'd0, 3'd0, 4'd5, 16'h0000, 16'h0022}, // R4 SC wrote
        {2'd0, 3'd4, 4'd5, 16'h0033, 16'h0000}, // R7 link consumed
        {2'd0, 3'd0, 4'd5, 16'h0000, 16'h0022}, // R7 no write
        {2'd0, 3'd3, 4'd3, 16'h0000, 16'h0000}, // R3 r0 links 3
        {2'd1, 3'd3, 4'd3, 16'h0000, 16'h0000}, // R3 r1 links 3
        {2'd1, 3'd1, 4'd3, 16'h0005, 16'h0000}, // R6 r1 stores to 3
        {2'd0, 3'd4, 4'd3, 16'h0006, 16'h0000}, // R6 r0 link broken
        {2'd1, 3'd4, 4'd3, 16'h0008, 16'h0001}, // R6 writer keeps link
        {2'd0, 3'd0, 4'd3, 16'h0000, 16'h0008}, // R4 value 8 stored
        {2'd2, 3'd3, 4'd2, 16'h0000, 16'h0000}, // R3 r2 links 2
        {2'd2, 3'd4, 4'd4, 16'h0009, 16'h0000}, // R5 address mismatch
        {2'd2, 3'd0, 4'd4, 16'h0000, 16'h0000}, // R5 no write
        {2'd2, 3'd4, 4'd2, 16'h0009, 16'h0000}, // R7 mismatch consumed link
        {2'd2, 3'd3, 4'd6, 16'h0000, 16'h0000}, // R3 r2 links 6
        {2'd3, 3'd2, 4'd6, 16'h0004, 16'h0000}, // R6 swap by r3
        {2'd2, 3'd4, 4'd6, 16'h0001, 16'h0000}, // R6 swap broke link
        {2'd2, 3'd0, 4'd6, 16'h0000, 16'h0004}, // R6 word is swap data
        {2'd3, 3'd2, 4'd9, 16'h0001, 16'h0000}, // R2 lock acquired
        {2'd0, 3'd2, 4'd9, 16'h0001, 16'h0001}, // R2 lock held
        {2'd3, 3'd1, 4'd9, 16'h0000, 16'h0000}, // R2 release by store 0
        {2'd0, 3'd2, 4'd9, 16'h0001, 16'h0000}, // R2 acquired after release
        {2'd1, 3'd3, 4'd9, 16'h0000, 16'h0001}, // R3 link on held lock
        {2'd1, 3'd4, 4'd9, 16'h0000, 16'h0001}, // R4 SC releases lock
        {2'd3, 3'd0, 4'd9, 16'h0000, 16'h0000}  // R4 lock word is 0
    };

    logic                clk = 1'b0;
    logic                rst_n = 1'b0;
    logic [NREQ-1:0]     req_valid = '0;
    logic [3*NREQ-1:0]   req_op = '0;
    logic [AW*NREQ-1:0]  req_addr = '0;
    logic [DW*NREQ-1:0]  req_wdata = '0;
    logic [NREQ-1:0]     gnt;
    logic                rsp_valid;
    logic [IW-1:0]       rsp_id;
    logic [DW-1:0]       rsp_data;
    int                  tests = 0;
    int                  fails = 0;

    always #10 clk = ~clk;

    atomic_mon #(.NREQ(NREQ), .AW(AW), .DW(DW)) u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
        .req_addr(req_addr), .req_wdata(req_wdata), .gnt(gnt),
        .rsp_valid(rsp_valid), .rsp_id(rsp_id), .rsp_data(rsp_data)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic string op_tag(input int op);
        case (op)
            0, 1:    return "R1";
            2:       return "R2";
            3:       return "R3";
            default: return "R4/R5/R6/R7";
        endcase
    endfunction

    task automatic do_reset();
        @(negedge clk);
        req_valid = '0;
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic issue(input int id, input int op, input int addr,
                         input logic [DW-1:0] wd, input logic [DW-1:0] exp,
                         input string tag);
        @(negedge clk);
        req_valid = '0;
        req_valid[id] = 1'b1;
        req_op[id*3 +: 3] = 3'(op);
        req_addr[id*AW +: AW] = AW'(addr);
        req_wdata[id*DW +: DW] = wd;
        #1;
        chk(gnt == NREQ'(1 << id), {tag, " R8 grant"}, 32'(gnt), 32'(1 << id));
        @(negedge clk);
        req_valid = '0;
        chk(rsp_valid == 1'b1, {tag, " R9 rsp_valid"}, 32'(rsp_valid), 32'd1);
        chk(rsp_id == IW'(id), {tag, " R9 rsp_id"}, 32'(rsp_id), 32'(id));
        chk(rsp_data == exp, {tag, " data"}, 32'(rsp_data), 32'(exp));
    endtask

    initial begin
        do_reset();
        #1;
        chk(rsp_valid == 1'b0 && gnt == '0, "R9 reset state", 32'(rsp_valid), 32'd0);

        for (int v = 0; v < NV; v++) begin
            issue(int'(VEC[v][40:39]), int'(VEC[v][38:36]), int'(VEC[v][35:32]),
                  VEC[v][31:16], VEC[v][15:0], op_tag(int'(VEC[v][38:36])));
        end

        // R8: all requesters asking continuously, pointer rotates from 0.
        do_reset();
        @(negedge clk);
        for (int i = 0; i < NREQ; i++) begin
            req_op[i*3 +: 3] = 3'd0;
            req_addr[i*AW +: AW] = AW'(i);
        end
        req_valid = '1;
        for (int k = 0; k < NREQ + 1; k++) begin
            #1;
            chk(gnt == NREQ'(1 << (k % NREQ)), "R8 rotation", 32'(gnt),
                32'(1 << (k % NREQ)));
            @(negedge clk);
            chk(rsp_valid && rsp_id == IW'(k % NREQ) && rsp_data == '0,
                "R9/R1 rotation response", 32'(rsp_id), 32'(k % NREQ));
        end
        // Last winner was 0: with 0 and 2 asking, 2 wins first, then 0.
        req_valid = 4'b0101;
        #1;
        chk(gnt == 4'b0100, "R8 skip idle", 32'(gnt), 32'h4);
        @(negedge clk);
        #1;
        chk(gnt == 4'b0001, "R8 wrap to 0", 32'(gnt), 32'h1);
        @(negedge clk);
        req_valid = '0;
        @(negedge clk);
        chk(rsp_valid == 1'b0, "R9 no rsp when idle", 32'(rsp_valid), 32'd0);

        // R7: reset drops links.
        issue(1, 3, 7, 16'h0, 16'h0, "R3 link before reset");
        do_reset();
        issue(1, 4, 7, 16'h00AA, 16'h0, "R7 link cleared by reset");
        issue(1, 0, 7, 16'h0, 16'h0, "R7 no write after reset");

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        #(200000 * 20);
        fails++;
        tests++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule